// File: doc/BRIEF.md
# Flash Write Pulse Sequencer

This block produces one programming pulse for a flash array, with the surrounding setup and recovery timing that the array needs. A controller raises a start request together with a two-bit width code. The block then masks the watchdog, raises the program-setup line and waits. Next it raises the program line for the selected width and drops it again. It keeps program-setup high for a hold interval, drops it, and waits out a recovery interval. Finally it unmasks the watchdog and pulses done for one cycle.

Every interval is a module parameter counted in clock cycles, and each parameter is at least 1. Three pulse widths are available: short, long and additional. The width is captured in the cycle the request is accepted. While the block is busy, new requests are ignored. Because start, the width code and all outputs are plain control levels, there is no data stream and no back-pressure. A caller that wants to issue a request simply holds start until it sees busy rise.

Top module: `flash_pulse_seq`

## Requirements
- R1: After reset, wdt_en_o is 1 and psetup_o, prog_o, busy_o and done_o are 0.
- R2: When start_i is 1 while busy_o is 0, then from the next cycle busy_o is 1 and wdt_en_o is 0. For that first cycle, psetup_o and prog_o are still 0.
- R3: psetup_o rises in the second cycle after acceptance and stays high for SETUP_CYC cycles before prog_o rises.
- R4: prog_o stays high for exactly the selected width, where the width code is sampled at acceptance: code 0 selects SHORT_CYC, 1 selects LONG_CYC, 2 selects ADD_CYC, and 3 selects SHORT_CYC.
- R5: After prog_o falls, psetup_o stays high for HOLD_CYC more cycles and then falls.
- R6: After psetup_o falls, all lines stay low with wdt_en_o at 0 for RECOV_CYC cycles. Then, in a single cycle, done_o is 1 and wdt_en_o returns to 1. In the following cycle done_o is 0 and busy_o is 0.
- R7: A start_i arriving while busy_o is 1 has no effect. This includes the done cycle, and it includes a request carrying a different width code. The running sequence keeps its timing and width.
- R8: prog_o is high only while psetup_o is high, and psetup_o is high only while wdt_en_o is 0.
- R9: A start_i raised in the first idle cycle after done is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one pulse sequence |
| width_i | input | 2 | Pulse width code: 0 short, 1 long, 2 additional, 3 short |
| wdt_en_o | output | 1 | Watchdog enable; 0 while masked |
| psetup_o | output | 1 | Program-setup line |
| prog_o | output | 1 | Program line |
| busy_o | output | 1 | Sequence in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase or counter value always shows up as an edge on a control line in the wrong cycle. For example, a stuck counter lengthens the pulse or the hold interval, and a skipped phase makes prog_o rise without a setup interval. Such a fault is visible within the same sequence, at most one full sequence length after the start. For this reason the bench compares all five outputs against an arithmetically computed waveform in every cycle of every sequence, for each width code. The waveform is unchanged while ignored requests are injected, so corrupted width capture or state is caught at the first cycle where it diverges.

// File: rtl/flash_pulse_pkg.sv
package flash_pulse_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WDOFF = 3'd1,
    PH_SETUP = 3'd2,
    PH_PULSE = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5,
    PH_DONE  = 3'd6
  } phase_t;

  typedef enum logic [1:0] {
    WC_SHORT = 2'd0,
    WC_LONG  = 2'd1,
    WC_ADD   = 2'd2,
    WC_ALT   = 2'd3
  } width_code_t;

  typedef struct packed {
    logic wdt_en;
    logic psetup;
    logic prog;
    logic busy;
    logic done;
  } ctrl_t;

  function automatic ctrl_t phase_ctrl(phase_t ph);
    ctrl_t c;
    c.wdt_en = (ph == PH_IDLE) || (ph == PH_DONE);
    c.psetup = (ph == PH_SETUP) || (ph == PH_PULSE) || (ph == PH_HOLD);
    c.prog   = (ph == PH_PULSE);
    c.busy   = (ph != PH_IDLE);
    c.done   = (ph == PH_DONE);
    return c;
  endfunction

endpackage

// File: rtl/flash_wait_counter.sv
module flash_wait_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/flash_width_sel.sv
module flash_width_sel
  import flash_pulse_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SHORT_CYC = 4,
  parameter int LONG_CYC  = 16,
  parameter int ADD_CYC   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] len_m1
);
  localparam logic [CNT_W-1:0] SHORT_M1 = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_M1  = CNT_W'(LONG_CYC - 1);
  localparam logic [CNT_W-1:0] ADD_M1   = CNT_W'(ADD_CYC - 1);

  logic [CNT_W-1:0] pick;

  always_comb begin
    case (width_code_t'(code))
      WC_LONG: pick = LONG_M1;
      WC_ADD:  pick = ADD_M1;
      default: pick = SHORT_M1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1 <= SHORT_M1;
    end else if (capture) begin
      len_m1 <= pick;
    end
  end
endmodule

// File: rtl/flash_phase_fsm.sv
module flash_phase_fsm
  import flash_pulse_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SETUP_CYC = 4,
  parameter int HOLD_CYC  = 2,
  parameter int RECOV_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             expired,
  input  logic [CNT_W-1:0] pulse_m1,
  output logic             accept,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output ctrl_t            ctrl
);
  localparam logic [CNT_W-1:0] SETUP_M1 = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_M1  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] RECOV_M1 = CNT_W'(RECOV_CYC - 1);

  phase_t ph, ph_nxt;

  always_comb begin
    ph_nxt = ph;
    case (ph)
      PH_IDLE:  if (start)   ph_nxt = PH_WDOFF;
      PH_WDOFF:              ph_nxt = PH_SETUP;
      PH_SETUP: if (expired) ph_nxt = PH_PULSE;
      PH_PULSE: if (expired) ph_nxt = PH_HOLD;
      PH_HOLD:  if (expired) ph_nxt = PH_RECOV;
      PH_RECOV: if (expired) ph_nxt = PH_DONE;
      PH_DONE:               ph_nxt = PH_IDLE;
      default:               ph_nxt = PH_IDLE;
    endcase
  end

  assign accept = (ph == PH_IDLE) && start;
  assign load   = (ph_nxt != ph);

  always_comb begin
    case (ph_nxt)
      PH_SETUP: load_val = SETUP_M1;
      PH_PULSE: load_val = pulse_m1;
      PH_HOLD:  load_val = HOLD_M1;
      PH_RECOV: load_val = RECOV_M1;
      default:  load_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      ctrl <= phase_ctrl(PH_IDLE);
    end else begin
      ph   <= ph_nxt;
      ctrl <= phase_ctrl(ph_nxt);
    end
  end
endmodule

// File: rtl/flash_pulse_seq.sv
module flash_pulse_seq
  import flash_pulse_pkg::*;
#(
  parameter int SETUP_CYC = 4,
  parameter int SHORT_CYC = 10,
  parameter int LONG_CYC  = 40,
  parameter int ADD_CYC   = 20,
  parameter int HOLD_CYC  = 3,
  parameter int RECOV_CYC = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] width_i,
  output logic       wdt_en_o,
  output logic       psetup_o,
  output logic       prog_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int MAX_B   = (RECOV_CYC > SHORT_CYC) ? RECOV_CYC : SHORT_CYC;
  localparam int MAX_C   = (LONG_CYC > ADD_CYC) ? LONG_CYC : ADD_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  logic             accept, load, expired;
  logic [CNT_W-1:0] load_val, pulse_m1;
  ctrl_t            ctrl;

  flash_width_sel #(
    .CNT_W(CNT_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC), .ADD_CYC(ADD_CYC)
  ) u_width (
    .clk(clk), .rst_n(rst_n), .capture(accept), .code(width_i), .len_m1(pulse_m1)
  );

  flash_phase_fsm #(
    .CNT_W(CNT_W), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_i), .expired(expired),
    .pulse_m1(pulse_m1), .accept(accept), .load(load), .load_val(load_val),
    .ctrl(ctrl)
  );

  flash_wait_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .expired(expired)
  );

  assign wdt_en_o = ctrl.wdt_en;
  assign psetup_o = ctrl.psetup;
  assign prog_o   = ctrl.prog;
  assign busy_o   = ctrl.busy;
  assign done_o   = ctrl.done;
endmodule

// File: rtl/flash_pulse_seq_chk.sv
module flash_pulse_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic wdt_en_o,
  input logic psetup_o,
  input logic prog_o,
  input logic busy_o,
  input logic done_o
);
  assert_prog_in_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |-> psetup_o);
  assert_setup_wdt_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    psetup_o |-> !wdt_en_o);
  assert_accept_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !wdt_en_o && !psetup_o));
  assert_setup_before_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_o) |-> $past(psetup_o));
  assert_hold_after_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_o) |-> psetup_o);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));
  assert_done_unmask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (wdt_en_o && !psetup_o));
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);
endmodule

bind flash_pulse_seq flash_pulse_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .wdt_en_o(wdt_en_o),
  .psetup_o(psetup_o), .prog_o(prog_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/flash_pulse_seq_test.sv
`timescale 1ns/1ps
module flash_pulse_seq_test;
  localparam int SU = 3, WS = 5, WL = 9, WA = 2, HO = 2, RC = 4;

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [1:0] width_i = 0;
  logic wdt_en_o, psetup_o, prog_o, busy_o, done_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  flash_pulse_seq #(.SETUP_CYC(SU), .SHORT_CYC(WS), .LONG_CYC(WL),
    .ADD_CYC(WA), .HOLD_CYC(HO), .RECOV_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .width_i(width_i),
    .wdt_en_o(wdt_en_o), .psetup_o(psetup_o), .prog_o(prog_o),
    .busy_o(busy_o), .done_o(done_o));

  function automatic int width_of(int code);
    return (code == 1) ? WL : (code == 2) ? WA : WS;
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {wdt,ps,pr,busy,done} actual %b expected %b at %0t",
               req, act, exp, $time);
    end
  endtask

  // Runs one sequence; if poke, raises start with other codes while busy (R7).
  task automatic run_seq(int code, bit poke);
    int w = width_of(code);
    int len = 2 + SU + w + HO + RC;
    start_i = 1; width_i = 2'(code);
    @(posedge clk); @(negedge clk);
    start_i = 0;
    for (int i = 1; i <= len + 1; i++) begin
      logic [4:0] e;
      string req;
      if (i == 1) begin e = 5'b00010; req = "R2"; end
      else if (i <= 1 + SU) begin e = 5'b01010; req = "R3"; end
      else if (i <= 1 + SU + w) begin e = 5'b01110; req = "R4"; end
      else if (i <= 1 + SU + w + HO) begin e = 5'b01010; req = "R5"; end
      else if (i <= 1 + SU + w + HO + RC) begin e = 5'b00010; req = "R6"; end
      else if (i == len) begin e = 5'b10011; req = "R6"; end
      else begin e = 5'b10000; req = "R6"; end
      if (poke && i <= len) req = {req, "/R7"};
      if (i == 1 && code == 3) req = {req, "/R4"};
      check(req, {wdt_en_o, psetup_o, prog_o, busy_o, done_o}, e);
      if (poke && i <= len && (i % 3 == 0 || i == len)) begin
        start_i = 1; width_i = 2'((code + i) % 4);
      end else begin
        start_i = 0;
      end
      if (i < len + 1) @(negedge clk);
    end
    start_i = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    start_i = 1; width_i = 1;
    repeat (3) @(negedge clk);
    check("R1", {wdt_en_o, psetup_o, prog_o, busy_o, done_o}, 5'b10000);
    start_i = 0;
    rst_n = 1;
    @(negedge clk);
    check("R1", {wdt_en_o, psetup_o, prog_o, busy_o, done_o}, 5'b10000);
    for (int code = 0; code < 4; code++) begin
      run_seq(code, 0);
      run_seq(code, 1);
    end
    // R9: back-to-back starts in first idle cycle, all code pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        run_seq(a, 0);
        run_seq(b, (a + b) % 2 == 1);
        check("R9 idle", {wdt_en_o, psetup_o, prog_o, busy_o, done_o}, 5'b10000);
      end
    repeat (3) @(negedge clk);
    check("R8 rest", {wdt_en_o, psetup_o, prog_o, busy_o, done_o}, 5'b10000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule